// File: doc/BRIEF.md
# Four-Tap Direct-Method Linear Convolver

This block takes two sequences of four unsigned 4-bit samples and returns all seven samples of their discrete linear convolution. It works the way long multiplication works on paper, except that no carry ever moves from one column to the next. Every output sample is the sum of the pairwise products that fall into its column.

A one-cycle `start` pulse captures both operand sequences. The second sequence is then read out of its holding register in reverse index order through a sample selector, and is shifted one sample per clock into a serial-in/parallel-out register. Once the fourth shift is done, every column is reduced in carry-save form with 3:2 counters. A carry-propagate adder finishes each column. All seven results are loaded into output registers in a single clock, and `done` is raised for one cycle. The results stay unchanged until the next run completes.

The reset `rst_n` is asynchronous and active low. Its deassertion must be synchronous to `clk`.

Top module: `conv4_direct`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy` and `done` are 0 and every field of `y_out` is 0. Asserting `rst_n` low in the middle of a run abandons that run.
- R2: Suppose `start` is sampled high at a rising edge while `busy` is 0. Then `busy` is high for exactly the next five cycles. `done` is high for exactly one cycle, the one that follows the fifth rising edge after the capturing edge, and `busy` is 0 in that cycle.
- R3: Let x_i be `x_in[4i+3:4i]` and h_j be `h_in[4j+3:4j]`. Then y_k, held in `y_out[10k+9:10k]` for k = 0..6, equals the sum of x_i·h_j over all i+j = k, as unsigned values.
- R4: Each column is summed on its own and loses no bits, up to the largest case. With all samples equal to 15, y = (225, 450, 675, 900, 675, 450, 225).
- R5: A `start` that arrives while `busy` is 1 is ignored. The running operation keeps its operands and its timing, and no extra `done` follows.
- R6: `x_in` and `h_in` are sampled only at the capturing edge. `y_out` changes only at the edge that raises `done`, and holds its value between completions.
- R7: If h has a single sample of value 1 at index j and zeros elsewhere, then y is x delayed by j samples, with zeros in all other positions.
- R8: `start` may be asserted in the cycle where `done` is high. A new run is then accepted with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a run; sampled only while idle |
| x_in | input | 16 | First sequence, sample i in bits [4i+3:4i] |
| h_in | input | 16 | Second sequence, sample j in bits [4j+3:4j] |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when `y_out` has been updated |
| y_out | output | 70 | Seven results, sample k in bits [10k+9:10k] |

## Verification
The two cases that are hardest to reach from the ports are a second `start` that lands in the middle of a run and a `start` placed exactly in the `done` cycle. Both depend on lining up a pulse with a single internal state. The bench reaches them by counting falling edges from the launch. In the first case it raises `start` again one cycle into the run, with different operands on the inputs, and then checks that the first operands' results appear at the unchanged latency. In the second case it raises `start` in the same falling-edge slot where `done` is first seen high, and then checks that the second result arrives six edges later.

// File: rtl/conv_pkg.sv
package conv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_SUM   = 2'd2
  } conv_state_e;
endpackage

// File: rtl/conv_tap_mux.sv
// Picks one stored sample of the second sequence; sel=0 yields the
// highest-index sample, so the shift order is time-reversed.
module conv_tap_mux #(
  parameter int SAMPLE_W = 4,
  parameter int TAPS     = 4,
  localparam int CNT_W   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic [TAPS*SAMPLE_W-1:0] store,
  input  logic [CNT_W-1:0]         sel,
  output logic [SAMPLE_W-1:0]      sample
);
  logic [TAPS-1:0][SAMPLE_W-1:0] slots;

  assign slots = store;

  always_comb begin
    sample = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (sel == CNT_W'(TAPS - 1 - i)) sample = slots[i];
    end
  end
endmodule

// File: rtl/conv_sipo.sv
// Serial-in/parallel-out register: new sample enters slot 0, older ones move up.
module conv_sipo #(
  parameter int SAMPLE_W = 4,
  parameter int TAPS     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [SAMPLE_W-1:0]      din,
  output logic [TAPS*SAMPLE_W-1:0] pout
);
  logic [TAPS-1:0][SAMPLE_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) begin
      for (int i = TAPS - 1; i > 0; i--) sr_d[i] = sr_q[i-1];
      sr_d[0] = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign pout = sr_q;
endmodule

// File: rtl/conv_col_sum.sv
// One output column: products with i+j == COL, reduced by 3:2 counters to
// a sum row and a carry row, then closed with one carry-propagate add.
module conv_col_sum #(
  parameter int SAMPLE_W = 4,
  parameter int TAPS     = 4,
  parameter int COL      = 0,
  parameter int SUM_W    = 10
) (
  input  logic [TAPS*SAMPLE_W-1:0] a_vec,
  input  logic [TAPS*SAMPLE_W-1:0] b_vec,
  output logic [SUM_W-1:0]         col_sum
);
  localparam int PAD = SUM_W - SAMPLE_W;

  logic [TAPS-1:0][SUM_W-1:0] pp;

  for (genvar i = 0; i < TAPS; i++) begin : g_pp
    localparam int J = COL - i;
    if (J >= 0 && J < TAPS) begin : g_on
      logic [SUM_W-1:0] a_ext, b_ext;
      assign a_ext = {{PAD{1'b0}}, a_vec[i*SAMPLE_W +: SAMPLE_W]};
      assign b_ext = {{PAD{1'b0}}, b_vec[J*SAMPLE_W +: SAMPLE_W]};
      assign pp[i] = a_ext * b_ext;
    end else begin : g_off
      assign pp[i] = '0;
    end
  end

  logic [SUM_W-1:0] s_row, c_row, s_nxt, c_nxt;

  always_comb begin
    s_row = pp[0];
    c_row = '0;
    s_nxt = '0;
    c_nxt = '0;
    for (int i = 1; i < TAPS; i++) begin
      s_nxt = s_row ^ c_row ^ pp[i];
      c_nxt = ((s_row & c_row) | (s_row & pp[i]) | (c_row & pp[i])) << 1;
      s_row = s_nxt;
      c_row = c_nxt;
    end
    col_sum = s_row + c_row;
  end
endmodule

// File: rtl/conv4_direct.sv
module conv4_direct #(
  parameter int SAMPLE_W = 4,
  parameter int TAPS     = 4,
  localparam int OUT_N   = 2 * TAPS - 1,
  localparam int SUM_W   = 2 * SAMPLE_W + $clog2(TAPS),
  localparam int CNT_W   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [TAPS*SAMPLE_W-1:0] x_in,
  input  logic [TAPS*SAMPLE_W-1:0] h_in,
  output logic                     busy,
  output logic                     done,
  output logic [OUT_N*SUM_W-1:0]   y_out
);
  import conv_pkg::*;

  conv_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TAPS*SAMPLE_W-1:0] x_q, h_q, b_par;
  logic [SAMPLE_W-1:0] tap;
  logic [OUT_N-1:0][SUM_W-1:0] col_res, y_q;
  logic done_q, cap_en, shift_en, load_en;

  assign cap_en   = start && (state_q == ST_IDLE);
  assign shift_en = (state_q == ST_SHIFT);
  assign load_en  = (state_q == ST_SUM);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(TAPS - 1)) state_d = ST_SUM;
      end
      ST_SUM:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= load_en;
    end
  end

  // operand capture, enabled only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      h_q <= '0;
    end else if (cap_en) begin
      x_q <= x_in;
      h_q <= h_in;
    end
  end

  conv_tap_mux #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_mux (
    .store  (h_q),
    .sel    (cnt_q),
    .sample (tap)
  );

  conv_sipo #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_sipo (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (tap),
    .pout     (b_par)
  );

  for (genvar k = 0; k < OUT_N; k++) begin : g_col
    conv_col_sum #(
      .SAMPLE_W (SAMPLE_W),
      .TAPS     (TAPS),
      .COL      (k),
      .SUM_W    (SUM_W)
    ) u_col (
      .a_vec   (x_q),
      .b_vec   (b_par),
      .col_sum (col_res[k])
    );
  end

  // result registers, enabled in the summing cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       y_q <= '0;
    else if (load_en) y_q <= col_res;
  end

  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;
  assign y_out = y_q;
endmodule

// File: rtl/conv4_direct_chk.sv
module conv4_direct_chk #(
  parameter int SAMPLE_W = 4,
  parameter int TAPS     = 4,
  localparam int OUT_N   = 2 * TAPS - 1,
  localparam int SUM_W   = 2 * SAMPLE_W + $clog2(TAPS),
  localparam int MAXV    = (1 << SAMPLE_W) - 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [OUT_N*SUM_W-1:0] y_out
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R2
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == 8'd5)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < 8'd5)); // R5
  AST_START_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && run_len < 8'd4) |=> busy); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(y_out)); // R6

  for (genvar k = 0; k < OUT_N; k++) begin : g_bound
    localparam int TERMS = (k < TAPS) ? k + 1 : OUT_N - k;
    AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      y_out[k*SUM_W +: SUM_W] <= SUM_W'(TERMS * MAXV * MAXV)); // R4
  end
endmodule

bind conv4_direct conv4_direct_chk #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .y_out (y_out)
);

// File: tb/conv4_direct_test.sv
`timescale 1ns/1ps
module conv4_direct_test;
  localparam int SW = 4;
  localparam int NT = 4;
  localparam int NO = 2 * NT - 1;
  localparam int YW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NT*SW-1:0] x_in = '0;
  logic [NT*SW-1:0] h_in = '0;
  logic busy, done;
  logic [NO*YW-1:0] y_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  conv4_direct uut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .x_in (x_in), .h_in (h_in),
    .busy (busy), .done (done), .y_out (y_out)
  );

  function automatic int ysamp(input logic [NO*YW-1:0] v, input int k);
    return int'(v[k*YW +: YW]);
  endfunction

  function automatic logic [NO*YW-1:0] golden(input logic [NT*SW-1:0] x,
                                               input logic [NT*SW-1:0] h);
    logic [NO*YW-1:0] r = '0;
    for (int k = 0; k < NO; k++) begin
      int acc = 0;
      for (int i = 0; i < NT; i++) begin
        int j = k - i;
        if (j >= 0 && j < NT) acc += int'(x[i*SW +: SW]) * int'(h[j*SW +: SW]);
      end
      r[k*YW +: YW] = YW'(acc);
    end
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_y(input string req, input logic [NO*YW-1:0] exp);
    for (int k = 0; k < NO; k++)
      check(req, $sformatf("y%0d", k), ysamp(y_out, k), ysamp(exp, k));
  endtask

  task automatic launch(input logic [NT*SW-1:0] x, input logic [NT*SW-1:0] h);
    @(negedge clk);
    start = 1'b1; x_in = x; h_in = h;
    @(negedge clk);
    start = 1'b0;
  endtask

  // count falling edges from the one after launch until done is seen
  task automatic await_done(input int first, output int lat);
    lat = first;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "done in reset", int'(done), 0);
    check_y("R1", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after release", int'(busy), 0);
    check("R1", "done after release", int'(done), 0);
  endtask

  task automatic t_doc_vector;
    logic [NT*SW-1:0] x = {4'd8, 4'd9, 4'd11, 4'd10};
    logic [NT*SW-1:0] h = {4'd13, 4'd12, 4'd14, 4'd15};
    logic [NO*YW-1:0] e = {10'd104, 10'd213, 10'd363, 10'd508,
                           10'd409, 10'd305, 10'd150};
    int lat;
    launch(x, h);
    check("R2", "busy after start", int'(busy), 1);
    await_done(1, lat);
    check("R2", "done latency", lat, 6);
    check("R2", "busy in done cycle", int'(busy), 0);
    check_y("R3", e);
    check_y("R3", golden(x, h));
    @(negedge clk);
    check("R2", "done width", int'(done), 0);
    check_y("R6", e);
  endtask

  task automatic t_full_scale;
    int lat;
    launch('1, '1);
    await_done(1, lat);
    check("R4", "latency", lat, 6);
    check_y("R4", {10'd225, 10'd450, 10'd675, 10'd900, 10'd675, 10'd450, 10'd225});
  endtask

  task automatic t_impulse;
    logic [NT*SW-1:0] x = {4'd3, 4'd7, 4'd12, 4'd5};
    int lat;
    launch(x, 16'h0100);
    await_done(1, lat);
    check_y("R7", {10'd0, 10'd3, 10'd7, 10'd12, 10'd5, 10'd0, 10'd0});
    launch(x, 16'h0001);
    await_done(1, lat);
    check_y("R7", {10'd0, 10'd0, 10'd0, 10'd3, 10'd7, 10'd12, 10'd5});
  endtask

  task automatic t_busy_start;
    logic [NT*SW-1:0] xa = {4'd1, 4'd2, 4'd3, 4'd4};
    logic [NT*SW-1:0] ha = {4'd9, 4'd0, 4'd6, 4'd2};
    int lat;
    int extra = 0;
    launch(xa, ha);
    start = 1'b1; x_in = '1; h_in = 16'h5a3c;
    @(negedge clk);
    start = 1'b0;
    x_in = 16'hffff; h_in = 16'h1234;
    await_done(2, lat);
    check("R5", "latency with restart attempt", lat, 6);
    check_y("R5", golden(xa, ha));
    check_y("R6", golden(xa, ha));
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    check("R5", "activity after ignored start", extra, 0);
  endtask

  task automatic t_back_to_back;
    logic [NT*SW-1:0] xa = {4'd6, 4'd0, 4'd15, 4'd1};
    logic [NT*SW-1:0] ha = {4'd2, 4'd8, 4'd4, 4'd11};
    logic [NT*SW-1:0] xb = {4'd14, 4'd5, 4'd5, 4'd9};
    logic [NT*SW-1:0] hb = {4'd1, 4'd3, 4'd10, 4'd7};
    int lat;
    launch(xa, ha);
    await_done(1, lat);
    check_y("R8", golden(xa, ha));
    start = 1'b1; x_in = xb; h_in = hb;
    @(negedge clk);
    start = 1'b0;
    check("R8", "busy after start in done cycle", int'(busy), 1);
    check_y("R6", golden(xa, ha));
    await_done(1, lat);
    check("R8", "second latency", lat, 6);
    check_y("R8", golden(xb, hb));
  endtask

  task automatic t_mid_reset;
    launch({4'd7, 4'd7, 4'd7, 4'd7}, {4'd3, 4'd3, 4'd3, 4'd3});
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "busy after mid-run reset", int'(busy), 0);
    check("R1", "done after mid-run reset", int'(done), 0);
    check_y("R1", '0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", "no done after abandoned run", int'(done), 0);
  endtask

  initial begin
    t_reset();
    t_doc_vector();
    t_full_scale();
    t_impulse();
    t_busy_start();
    t_back_to_back();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule